// File: doc/BRIEF.md
# Stereo Zero-Cross Gain Update Controller

This block decides when a newly written gain code becomes the gain in effect on each of two audio channels. Each channel has a 4-bit gain code input with a write strobe and a zero-cross enable level. With the enable low, a written code takes effect at once. With the enable high, the code is held as pending. It is applied at the first sample strobe that shows a zero crossing on that channel's signed sample stream, or when a timeout counted in sample strobes runs out, whichever happens first.

The timeout is counted in samples rather than in clock cycles, so it scales with the sample rate. The default of 768 samples is 16 ms at a 48 kHz base rate and about 17.4 ms at 44.1 kHz. The block drives out the active code of each channel, its value in decibels, and a one-cycle pulse whenever the active code changes. Applying the gain to the signal is left to the circuit that uses these outputs.

Top module: `zcg_gain_ctrl`

## Requirements
- R1: The left and right channels are fully independent. Writes, samples and pending changes on one channel never alter the other channel's active code, decibel output or update pulse.
- R2: The decibel output is twice the code for codes 0 to 9 (0 to 18 dB). Codes 10 to 15 give 21, 24, 27, 30, 33 and 36 dB. It never exceeds 36.
- R3: With the zero-cross enable at 0, a write sets the active code to the written code at the clock edge that accepts the write. Any change already pending on that channel is cancelled.
- R4: With the zero-cross enable at 1, a write of a code different from the current target makes it pending. The pending code is applied at the first later sample strobe whose sample either is exactly zero or has a sign bit different from the sample of the previous strobe. Without a strobe, the active code does not change.
- R5: A pending code with no zero crossing is applied on the TIMEOUT-th sample strobe after the write that made it pending. TIMEOUT defaults to 768.
- R6: A zero-cross write of the code that is already the target (pending code, or active code when nothing is pending) changes nothing. An earlier pending change still times out counted from its original write.
- R7: A zero-cross write of a different code while a change is pending replaces the pending code and restarts the timeout count from that write.
- R8: The update output of a channel is high for exactly the cycles in which that channel's active code differs from its value one cycle earlier.
- R9: After reset both active codes are 0 (0 dB), nothing is pending and both update outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sampleStb | input | 1 | One-cycle strobe marking a new sample on both channels |
| sampleL | input | SAMPLE_W | Left signed sample, valid with sampleStb |
| sampleR | input | SAMPLE_W | Right signed sample, valid with sampleStb |
| wrEnL | input | 1 | Left gain code write strobe |
| wrCodeL | input | 4 | Left gain code to write |
| zcEnL | input | 1 | Left zero-cross enable |
| wrEnR | input | 1 | Right gain code write strobe |
| wrCodeR | input | 4 | Right gain code to write |
| zcEnR | input | 1 | Right zero-cross enable |
| gainL | output | 4 | Left active gain code |
| gainR | output | 4 | Right active gain code |
| dbL | output | 6 | Left active gain in dB |
| dbR | output | 6 | Right active gain in dB |
| updL | output | 1 | Left active code changed this cycle |
| updR | output | 1 | Right active code changed this cycle |

## Verification
The assertions assume that a write strobe lasts a single cycle and that the zero-cross enable is steady while it is high. They also assume that the active code moves only at a write edge or at a sample strobe, so a cycle with neither must leave it unchanged. The stimulus drives every write and strobe as a single-cycle pulse placed between clock edges. It changes each enable only in cycles without a write, and it never lets a sample value matter outside a strobe cycle.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
  localparam int CODE_W = 4;
  localparam int DB_W   = 6;

  // strobes from the channel control to its datapath
  typedef struct packed {
    logic takeWrite;   // latch written code as new target
    logic loadDirect;  // active <= written code
    logic applyPend;   // active <= pending code
    logic clrCnt;      // restart timeout count
    logic countEn;     // advance timeout count
  } zcgStrobe_t;
endpackage

// File: rtl/zcg_ctrl.sv
module zcg_ctrl
  import zcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              zcEn,
  input  logic [CODE_W-1:0] wrCode,
  input  logic [CODE_W-1:0] pendCode,
  input  logic              stb,
  input  logic              zeroCross,
  input  logic              cntDone,
  output zcgStrobe_t        strb
);
  logic pending, pendingNext;
  logic differs;

  assign differs = (wrCode != pendCode);

  always_comb begin
    strb        = '0;
    pendingNext = pending;
    if (wrEn && !zcEn) begin
      strb.takeWrite  = 1'b1;
      strb.loadDirect = 1'b1;
      strb.clrCnt     = 1'b1;
      pendingNext     = 1'b0;
    end else if (wrEn && differs) begin
      strb.takeWrite = 1'b1;
      strb.clrCnt    = 1'b1;
      pendingNext    = 1'b1;
    end else if (pending && stb) begin
      if (zeroCross || cntDone) begin
        strb.applyPend = 1'b1;
        strb.clrCnt    = 1'b1;
        pendingNext    = 1'b0;
      end else begin
        strb.countEn = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= pendingNext;
  end
endmodule

// File: rtl/zcg_datapath.sv
module zcg_datapath
  import zcg_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int TIMEOUT  = 768
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       stb,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic [CODE_W-1:0]          wrCode,
  input  zcgStrobe_t                 strb,
  output logic [CODE_W-1:0]          pendCode,
  output logic                       zeroCross,
  output logic                       cntDone,
  output logic [CODE_W-1:0]          actCode,
  output logic [DB_W-1:0]            db,
  output logic                       upd
);
  localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt;
  logic             prevSign;
  logic             signNow;

  assign signNow   = sample[SAMPLE_W-1];
  assign zeroCross = stb && ((sample == '0) || (signNow != prevSign));
  assign cntDone   = (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevSign <= 1'b0;
      pendCode <= '0;
      actCode  <= '0;
      cnt      <= '0;
      upd      <= 1'b0;
    end else begin
      if (stb) prevSign <= signNow;
      if (strb.takeWrite) pendCode <= wrCode;
      if (strb.clrCnt)       cnt <= '0;
      else if (strb.countEn) cnt <= cnt + 1'b1;
      if (strb.loadDirect)     actCode <= wrCode;
      else if (strb.applyPend) actCode <= pendCode;
      upd <= (strb.loadDirect && (wrCode != actCode)) ||
             (strb.applyPend && (pendCode != actCode));
    end
  end

  // 2 dB steps up to code 9, 3 dB steps above
  always_comb begin
    if (actCode <= CODE_W'(9))
      db = {1'b0, actCode, 1'b0};
    else
      db = {2'b00, actCode} + {1'b0, actCode, 1'b0} - DB_W'(9);
  end
endmodule

// File: rtl/zcg_gain_ctrl.sv
module zcg_gain_ctrl
  import zcg_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int TIMEOUT  = 768
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sampleStb,
  input  logic signed [SAMPLE_W-1:0] sampleL,
  input  logic signed [SAMPLE_W-1:0] sampleR,
  input  logic                       wrEnL,
  input  logic [CODE_W-1:0]          wrCodeL,
  input  logic                       zcEnL,
  input  logic                       wrEnR,
  input  logic [CODE_W-1:0]          wrCodeR,
  input  logic                       zcEnR,
  output logic [CODE_W-1:0]          gainL,
  output logic [CODE_W-1:0]          gainR,
  output logic [DB_W-1:0]            dbL,
  output logic [DB_W-1:0]            dbR,
  output logic                       updL,
  output logic                       updR
);
  localparam int NCH = 2;

  logic signed [SAMPLE_W-1:0] smp  [NCH];
  logic                       wrE  [NCH];
  logic [CODE_W-1:0]          wrC  [NCH];
  logic                       zcE  [NCH];
  logic [CODE_W-1:0]          act  [NCH];
  logic [DB_W-1:0]            dbV  [NCH];
  logic                       updV [NCH];

  assign smp[0] = sampleL;  assign smp[1] = sampleR;
  assign wrE[0] = wrEnL;    assign wrE[1] = wrEnR;
  assign wrC[0] = wrCodeL;  assign wrC[1] = wrCodeR;
  assign zcE[0] = zcEnL;    assign zcE[1] = zcEnR;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    zcgStrobe_t        strb;
    logic [CODE_W-1:0] pendCode;
    logic              zeroCross;
    logic              cntDone;

    zcg_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .wrEn(wrE[ch]), .zcEn(zcE[ch]),
      .wrCode(wrC[ch]), .pendCode(pendCode), .stb(sampleStb),
      .zeroCross(zeroCross), .cntDone(cntDone), .strb(strb)
    );

    zcg_datapath #(.SAMPLE_W(SAMPLE_W), .TIMEOUT(TIMEOUT)) u_dp (
      .clk(clk), .rst_n(rst_n), .stb(sampleStb), .sample(smp[ch]),
      .wrCode(wrC[ch]), .strb(strb), .pendCode(pendCode),
      .zeroCross(zeroCross), .cntDone(cntDone), .actCode(act[ch]),
      .db(dbV[ch]), .upd(updV[ch])
    );
  end

  assign gainL = act[0];  assign gainR = act[1];
  assign dbL   = dbV[0];  assign dbR   = dbV[1];
  assign updL  = updV[0]; assign updR  = updV[1];
endmodule

// File: rtl/zcg_checker.sv
module zcg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       stb,
  input logic       wr,
  input logic       zcEn,
  input logic [3:0] wrCode,
  input logic [3:0] gain,
  input logic [5:0] db,
  input logic       upd
);
  p_direct_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !zcEn) |=> (gain == $past(wrCode)));

  p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !stb) |=> $stable(gain));

  p_upd_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gain != $past(gain)) |-> upd);

  p_upd_only_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> (gain != $past(gain)));

  p_db_ceiling_r2: assert property (@(posedge clk) disable iff (!rst_n)
    db <= 6'd36);
endmodule

bind zcg_gain_ctrl zcg_checker chkL (
  .clk(clk), .rst_n(rst_n), .stb(sampleStb), .wr(wrEnL), .zcEn(zcEnL),
  .wrCode(wrCodeL), .gain(gainL), .db(dbL), .upd(updL)
);

bind zcg_gain_ctrl zcg_checker chkR (
  .clk(clk), .rst_n(rst_n), .stb(sampleStb), .wr(wrEnR), .zcEn(zcEnR),
  .wrCode(wrCodeR), .gain(gainR), .db(dbR), .upd(updR)
);

// File: tb/sim_zcg_gain_ctrl.sv
module sim_zcg_gain_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleStb = 1'b0;
  logic signed [15:0] sampleL = 16'sd100, sampleR = 16'sd100;
  logic wrEnL = 1'b0, wrEnR = 1'b0, zcEnL = 1'b0, zcEnR = 1'b0;
  logic [3:0] wrCodeL = '0, wrCodeR = '0;
  logic [3:0] gainL, gainR;
  logic [5:0] dbL, dbR;
  logic updL, updR;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zcg_gain_ctrl #(.SAMPLE_W(16), .TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb),
    .sampleL(sampleL), .sampleR(sampleR),
    .wrEnL(wrEnL), .wrCodeL(wrCodeL), .zcEnL(zcEnL),
    .wrEnR(wrEnR), .wrCodeR(wrCodeR), .zcEnR(zcEnR),
    .gainL(gainL), .gainR(gainR), .dbL(dbL), .dbR(dbR),
    .updL(updL), .updR(updR)
  );

  function automatic int expDb(int c);
    if (c < 8)       return 2 * c;
    else if (c < 10) return 16 + 2 * (c - 8);
    else             return 21 + 3 * (c - 10);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic writeL(input int c, input bit zc);
    zcEnL = zc; wrCodeL = 4'(c); wrEnL = 1'b1; tick(); wrEnL = 1'b0;
  endtask

  task automatic writeR(input int c, input bit zc);
    zcEnR = zc; wrCodeR = 4'(c); wrEnR = 1'b1; tick(); wrEnR = 1'b0;
  endtask

  task automatic strobe(input int sl, input int sr);
    sampleL = 16'(sl); sampleR = 16'(sr); sampleStb = 1'b1; tick(); sampleStb = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev;
    repeat (3) tick();
    // R9 reset state
    chk(gainL == 0 && gainR == 0, "R9 gains after reset", gainL, 0);
    chk(dbL == 0 && dbR == 0, "R9 dB after reset", dbL, 0);
    chk(!updL && !updR, "R9 pulses after reset", updL, 0);
    rst_n = 1'b1;
    tick();

    // R2 / R3 / R8 / R1: direct sweep, right channel runs the reverse order
    prev = 0;
    for (int c = 0; c < 16; c++) begin
      writeL(c, 1'b0);
      chk(gainL == 4'(c), "R3 direct load left", gainL, c);
      chk(int'(dbL) == expDb(c), "R2 dB left", dbL, expDb(c));
      chk(updL == (c != prev), "R8 pulse on left change", updL, c != prev);
      chk(!updR, "R1 right pulse quiet", updR, 0);
      tick();
      chk(!updL, "R8 pulse one cycle", updL, 0);
      writeR(15 - c, 1'b0);
      chk(gainR == 4'(15 - c), "R3 direct load right", gainR, 15 - c);
      chk(int'(dbR) == expDb(15 - c), "R2 dB right", dbR, expDb(15 - c));
      chk(gainL == 4'(c), "R1 left untouched by right write", gainL, c);
      prev = c;
    end
    // left 15, right 0

    // R4 sign-change crossing
    strobe(100, 100);
    writeL(4, 1'b1);
    chk(gainL == 15, "R4 pending not yet applied", gainL, 15);
    for (int k = 0; k < 3; k++) strobe(200, 300);
    chk(gainL == 15, "R4 no crossing keeps gain", gainL, 15);
    strobe(-5, 300);
    chk(gainL == 4 && updL, "R4 applied on sign change", gainL, 4);
    chk(gainR == 0 && !updR, "R1 right unaffected by left crossing", gainR, 0);

    // R4 exact-zero crossing
    writeL(6, 1'b1);
    strobe(-7, 300); strobe(-7, 300);
    chk(gainL == 4, "R4 same sign holds", gainL, 4);
    strobe(0, 300);
    chk(gainL == 6, "R4 zero sample is a crossing", gainL, 6);

    // R4 no strobe, no apply (prev sign now non-negative)
    writeL(2, 1'b1);
    sampleL = -16'sd40;
    repeat (TO + 3) tick();
    chk(gainL == 6, "R4 sign change without strobe ignored", gainL, 6);
    strobe(-40, 300);
    chk(gainL == 2, "R4 applied on strobed crossing", gainL, 2);

    // R5 timeout, prev sign negative
    writeL(11, 1'b1);
    for (int k = 0; k < TO - 1; k++) strobe(-1, 300);
    chk(gainL == 2, "R5 not before timeout", gainL, 2);
    strobe(-1, 300);
    chk(gainL == 11 && updL, "R5 applied at timeout", gainL, 11);

    // R6 same-code rewrite keeps original timing
    writeL(12, 1'b1);
    for (int k = 0; k < 5; k++) strobe(-1, 300);
    writeL(12, 1'b1);
    for (int k = 0; k < TO - 6; k++) strobe(-1, 300);
    chk(gainL == 11, "R6 still pending", gainL, 11);
    strobe(-1, 300);
    chk(gainL == 12, "R6 times out from first write", gainL, 12);
    writeL(12, 1'b1);
    for (int k = 0; k < TO + 2; k++) strobe(-1, 300);
    chk(gainL == 12 && !updL, "R6 rewrite of active code no change", gainL, 12);

    // R7 replacement restarts the count
    writeL(13, 1'b1);
    for (int k = 0; k < 5; k++) strobe(-1, 300);
    writeL(14, 1'b1);
    for (int k = 0; k < TO - 1; k++) strobe(-1, 300);
    chk(gainL == 12, "R7 restarted count still pending", gainL, 12);
    strobe(-1, 300);
    chk(gainL == 14, "R7 replaced code applied", gainL, 14);

    // R3 direct write cancels a pending change
    writeL(3, 1'b1);
    strobe(-1, 300); strobe(-1, 300);
    writeL(7, 1'b0);
    chk(gainL == 7, "R3 direct write during pending", gainL, 7);
    zcEnL = 1'b1;
    for (int k = 0; k < TO + 2; k++) strobe(-1, 300);
    chk(gainL == 7, "R3 pending cancelled", gainL, 7);

    // R1 right channel crossing on its own stream
    writeR(9, 1'b1);
    strobe(-1, 300);
    chk(gainR == 0, "R1 right waits for own crossing", gainR, 0);
    strobe(50, -300);
    chk(gainR == 9 && gainL == 7, "R1 right applies independently", gainR, 9);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule